// File: doc/BRIEF.md
# FlexRay Frame Header Parser

This block sits behind a bit deframer that has already removed the byte start sequences and recovered bit timing. It receives the frame one bit per strobe, with a start flag on the first bit, and splits the header into its indicator flags, frame identifier, payload length and cycle count. While the header arrives it runs the 11-bit header checksum serially and compares it with the received checksum field. It also checks the header consistency rules. After the header it packs the payload bits into bytes, most significant bit first.

The payload byte count (twice the length field, which counts 16-bit words) is driven back to the deframer as soon as the length field is complete. A completion pulse marks the end of the payload. For an empty payload this pulse comes with the header-done pulse. Once the payload is complete, further bits are ignored until the next start flag.

Top module: `fr_hdr_parse`

## Requirements
- R1: After reset, `hdr_done`, `byte_vld`, `pay_done`, `hcrc_ok` and `fld_err` are 0 and `frame_id` is 0.
- R2: A strobed bit with `sof` high is frame bit 0. Bits 1, 2, 3, 4 and 5 set `f_reserved`, `f_ppi`, `f_nfi`, `f_sync` and `f_startup`. `hdr_done` pulses for one cycle, in the cycle after bit 40 is accepted, exactly once per complete frame.
- R3: Frame bits 6..16 give `frame_id`, bits 17..23 give `pay_words` and bits 35..40 give `cycle_cnt`. Each field is sent MSB first and is valid while `hdr_done` is high.
- R4: `pay_bytes` equals twice `pay_words` from the cycle after bit 23 is accepted.
- R5: The header checksum is computed MSB first over frame bits 4..23. Its register starts at 0x01A. Each bit shifts the register left one place, and the register is XORed with 0x385 when the bit XOR the old register MSB is 1. No final XOR is applied. `hcrc_ok` is 1 at `hdr_done` exactly when this value equals bits 24..34, read MSB first.
- R6: At `hdr_done`, `fld_err` is 1 exactly when the frame ID is 0, or when the startup flag is 1 with the sync flag 0, or when the preamble flag is 1 with the null-frame flag 0 (0 marks a null frame). The header fields are reported even when `fld_err` is 1.
- R7: Payload bits start at frame bit 41 and are packed MSB first. `byte_vld` pulses with `byte_data` in the cycle after the eighth bit of each byte is accepted.
- R8: `pay_done` pulses together with the last `byte_vld` of the frame. When `pay_words` is 0, it pulses together with `hdr_done`.
- R9: Cycles with `bit_vld` low have no effect. Bits strobed without `sof` after `pay_done` produce no `byte_vld`, `hdr_done` or `pay_done`.
- R10: `sof` in the middle of a frame drops the partial frame and restarts parsing at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_vld | input | 1 | Strobe: `bit_in` carries a frame bit |
| bit_in | input | 1 | Frame bit value |
| sof | input | 1 | Qualifies the strobed bit as frame bit 0 |
| hdr_done | output | 1 | Header complete pulse |
| f_reserved | output | 1 | Reserved bit |
| f_ppi | output | 1 | Payload preamble indicator |
| f_nfi | output | 1 | Null-frame indicator (1 = data frame) |
| f_sync | output | 1 | Sync indicator |
| f_startup | output | 1 | Startup indicator |
| frame_id | output | 11 | Frame identifier |
| pay_words | output | 7 | Payload length in 16-bit words |
| pay_bytes | output | 8 | Payload length in bytes, to the deframer |
| cycle_cnt | output | 6 | Cycle count |
| hcrc_ok | output | 1 | Header checksum matched |
| fld_err | output | 1 | Header rule violated |
| byte_vld | output | 1 | Payload byte strobe |
| byte_data | output | 8 | Payload byte |
| pay_done | output | 1 | Payload complete pulse |

## Verification
`pay_done` can fall in the same cycle as two other events. For an empty payload it coincides with `hdr_done`. For a non-empty payload it coincides with the last `byte_vld`. The vector table includes frames with zero and non-zero lengths, sent with idle gaps of different lengths between strobes. On every sampled cycle the bench checks that `pay_done` appears only together with the matching companion pulse and never alone. Trailing bits after each frame confirm that no further pulse follows.

// File: rtl/fr_hdr_pkg.sv
package fr_hdr_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_HDR  = 2'd1,
      PH_PAY  = 2'd2
   } ph_t;

   // position of the first header rule/flag bits; fixed by the frame layout
   localparam int P_RSV  = 1;
   localparam int P_PPI  = 2;
   localparam int P_NFI  = 3;
   localparam int P_SYN  = 4;
   localparam int P_STU  = 5;
   localparam int P_ID0  = 6;
endpackage

// File: rtl/fr_hcrc.sv
module fr_hcrc #(
   parameter int          W    = 11,
   parameter logic [W-1:0] POLY = 11'h385,
   parameter logic [W-1:0] INIT = 11'h01A
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init,
   input  logic         en,
   input  logic         d,
   output logic [W-1:0] crc
);
   generate
      if (W < 2) begin : g_bad_w
         $error("fr_hcrc: W must be at least 2");
      end
   endgenerate

   logic         fb;
   logic [W-1:0] nxt;

   assign fb = crc[W-1] ^ d;

   genvar g;
   generate
      for (g = 0; g < W; g++) begin : g_tap
         if (g == 0) begin : g_lsb
            assign nxt[g] = fb & POLY[g];
         end else begin : g_up
            assign nxt[g] = crc[g-1] ^ (fb & POLY[g]);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc <= INIT;
      else if (init) crc <= INIT;
      else if (en)   crc <= nxt;
   end

   p_crc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!init && !en) |=> $stable(crc));
endmodule

// File: rtl/fr_bit_seq.sv
module fr_bit_seq
   import fr_hdr_pkg::*;
#(
   parameter int P_HEND = 40,
   parameter int CNT_W  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_vld,
   input  logic             sof,
   input  logic             len_zero,
   input  logic             pay_last,
   output logic             take_hdr,
   output logic             take_pay,
   output logic [CNT_W-1:0] idx,
   output logic             hdr_last
);
   localparam logic [CNT_W-1:0] I_HEND = CNT_W'(P_HEND);

   generate
      if ((1 << CNT_W) <= P_HEND) begin : g_bad_cnt
         $error("fr_bit_seq: CNT_W too small for header length");
      end
   endgenerate

   ph_t              ph;
   logic [CNT_W-1:0] cnt;

   assign idx      = sof ? '0 : cnt;
   assign take_hdr = bit_vld && (sof || ph == PH_HDR);
   assign take_pay = bit_vld && !sof && ph == PH_PAY;
   assign hdr_last = take_hdr && idx == I_HEND;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= PH_IDLE;
         cnt <= '0;
      end else if (take_hdr) begin
         cnt <= idx + 1'b1;
         if (hdr_last) ph <= len_zero ? PH_IDLE : PH_PAY;
         else          ph <= PH_HDR;
      end else if (take_pay && pay_last) begin
         ph <= PH_IDLE;
      end
   end

   p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld && sof) |=> (ph == PH_HDR && cnt == CNT_W'(1)));
endmodule

// File: rtl/fr_hdr_fields.sv
module fr_hdr_fields
   import fr_hdr_pkg::*;
#(
   parameter int          ID_W        = 11,
   parameter int          LEN_W       = 7,
   parameter int          CYC_W       = 6,
   parameter int          CRC_W       = 11,
   parameter int          CNT_W       = 6,
   parameter bit          CHECK_RULES = 1'b1,
   parameter logic [CRC_W-1:0] POLY   = 11'h385,
   parameter logic [CRC_W-1:0] INIT   = 11'h01A
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [CNT_W-1:0] idx,
   input  logic             b,
   output logic             rsv,
   output logic             ppi,
   output logic             nfi,
   output logic             syn,
   output logic             stu,
   output logic [ID_W-1:0]  id,
   output logic [LEN_W-1:0] len,
   output logic [CYC_W-1:0] cyc,
   output logic             hcrc_ok,
   output logic             fld_err,
   output logic             hdr_done
);
   localparam int P_LEN0 = P_ID0 + ID_W;
   localparam int P_CRC0 = P_LEN0 + LEN_W;
   localparam int P_CYC0 = P_CRC0 + CRC_W;
   localparam int P_HEND = P_CYC0 + CYC_W - 1;

   localparam logic [CNT_W-1:0] I_RSV  = CNT_W'(P_RSV);
   localparam logic [CNT_W-1:0] I_PPI  = CNT_W'(P_PPI);
   localparam logic [CNT_W-1:0] I_NFI  = CNT_W'(P_NFI);
   localparam logic [CNT_W-1:0] I_SYN  = CNT_W'(P_SYN);
   localparam logic [CNT_W-1:0] I_STU  = CNT_W'(P_STU);
   localparam logic [CNT_W-1:0] I_ID0  = CNT_W'(P_ID0);
   localparam logic [CNT_W-1:0] I_LEN0 = CNT_W'(P_LEN0);
   localparam logic [CNT_W-1:0] I_CRC0 = CNT_W'(P_CRC0);
   localparam logic [CNT_W-1:0] I_CYC0 = CNT_W'(P_CYC0);
   localparam logic [CNT_W-1:0] I_CEND = CNT_W'(P_CYC0 - 1);
   localparam logic [CNT_W-1:0] I_HEND = CNT_W'(P_HEND);

   generate
      if (ID_W < 2 || LEN_W < 2 || CYC_W < 2 || CRC_W < 2) begin : g_bad_w
         $error("fr_hdr_fields: field widths must be at least 2");
      end
   endgenerate

   logic             crc_init, crc_en;
   logic [CRC_W-1:0] crc_calc;
   logic [CRC_W-1:0] rcrc;
   logic             rule_err;

   // checksum window: sync bit up to the last length bit
   assign crc_init = take && idx == '0;
   assign crc_en   = take && idx >= I_SYN && idx < I_CRC0;

   fr_hcrc #(.W(CRC_W), .POLY(POLY), .INIT(INIT)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (crc_init),
      .en    (crc_en),
      .d     (b),
      .crc   (crc_calc)
   );

   generate
      if (CHECK_RULES) begin : g_rules
         assign rule_err = (id == '0) || (stu && !syn) || (ppi && !nfi);
         p_id_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (hdr_done && id == '0) |-> fld_err);
      end else begin : g_norules
         assign rule_err = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsv      <= 1'b0;
         ppi      <= 1'b0;
         nfi      <= 1'b0;
         syn      <= 1'b0;
         stu      <= 1'b0;
         id       <= '0;
         len      <= '0;
         rcrc     <= '0;
         cyc      <= '0;
         hcrc_ok  <= 1'b0;
         fld_err  <= 1'b0;
         hdr_done <= 1'b0;
      end else begin
         hdr_done <= take && idx == I_HEND;
         if (take) begin
            if (idx == I_RSV) rsv <= b;
            if (idx == I_PPI) ppi <= b;
            if (idx == I_NFI) nfi <= b;
            if (idx == I_SYN) syn <= b;
            if (idx == I_STU) stu <= b;
            if (idx >= I_ID0  && idx < I_LEN0) id   <= {id[ID_W-2:0], b};
            if (idx >= I_LEN0 && idx < I_CRC0) len  <= {len[LEN_W-2:0], b};
            if (idx >= I_CRC0 && idx < I_CYC0) rcrc <= {rcrc[CRC_W-2:0], b};
            if (idx >= I_CYC0 && idx <= I_HEND) cyc <= {cyc[CYC_W-2:0], b};
            if (idx == I_CEND) hcrc_ok <= ({rcrc[CRC_W-2:0], b} == crc_calc);
            if (idx == I_HEND) fld_err <= rule_err;
         end
      end
   end

   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_done |=> !hdr_done);
endmodule

// File: rtl/fr_pay_bytes.sv
module fr_pay_bytes #(
   parameter int LEN_W  = 7,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              take,
   input  logic              b,
   input  logic [LEN_W:0]    nbytes,
   output logic              byte_vld,
   output logic [BYTE_W-1:0] byte_data,
   output logic              last
);
   localparam int BI_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
   localparam logic [BI_W-1:0] BI_END = BI_W'(BYTE_W - 1);

   generate
      if (BYTE_W < 2) begin : g_bad_w
         $error("fr_pay_bytes: BYTE_W must be at least 2");
      end
   endgenerate

   logic [BYTE_W-1:0] sh;
   logic [BI_W-1:0]   bi;
   logic [LEN_W:0]    bc;
   logic              byte_end;

   assign byte_end = take && bi == BI_END;
   assign last     = byte_end && (bc == nbytes - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh        <= '0;
         bi        <= '0;
         bc        <= '0;
         byte_vld  <= 1'b0;
         byte_data <= '0;
      end else begin
         byte_vld <= byte_end;
         if (byte_end) byte_data <= {sh[BYTE_W-2:0], b};
         if (start) begin
            bi <= '0;
            bc <= '0;
         end else if (take) begin
            sh <= {sh[BYTE_W-2:0], b};
            bi <= byte_end ? '0 : bi + 1'b1;
            if (byte_end) bc <= bc + 1'b1;
         end
      end
   end

   p_byte_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |=> !byte_vld);
endmodule

// File: rtl/fr_hdr_parse.sv
module fr_hdr_parse #(
   parameter int          ID_W        = 11,
   parameter int          LEN_W       = 7,
   parameter int          CYC_W       = 6,
   parameter int          CRC_W       = 11,
   parameter int          BYTE_W      = 8,
   parameter bit          CHECK_RULES = 1'b1,
   parameter logic [CRC_W-1:0] POLY   = 11'h385,
   parameter logic [CRC_W-1:0] INIT   = 11'h01A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_vld,
   input  logic              bit_in,
   input  logic              sof,
   output logic              hdr_done,
   output logic              f_reserved,
   output logic              f_ppi,
   output logic              f_nfi,
   output logic              f_sync,
   output logic              f_startup,
   output logic [ID_W-1:0]   frame_id,
   output logic [LEN_W-1:0]  pay_words,
   output logic [LEN_W:0]    pay_bytes,
   output logic [CYC_W-1:0]  cycle_cnt,
   output logic              hcrc_ok,
   output logic              fld_err,
   output logic              byte_vld,
   output logic [BYTE_W-1:0] byte_data,
   output logic              pay_done
);
   localparam int P_HEND = fr_hdr_pkg::P_ID0 + ID_W + LEN_W + CRC_W + CYC_W - 1;
   localparam int CNT_W  = $clog2(P_HEND + 1);

   logic             take_hdr, take_pay, hdr_last, pay_last, len_zero;
   logic [CNT_W-1:0] idx;

   assign len_zero  = (pay_words == '0);
   assign pay_bytes = {pay_words, 1'b0};

   fr_bit_seq #(.P_HEND(P_HEND), .CNT_W(CNT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_vld  (bit_vld),
      .sof      (sof),
      .len_zero (len_zero),
      .pay_last (pay_last),
      .take_hdr (take_hdr),
      .take_pay (take_pay),
      .idx      (idx),
      .hdr_last (hdr_last)
   );

   fr_hdr_fields #(
      .ID_W(ID_W), .LEN_W(LEN_W), .CYC_W(CYC_W), .CRC_W(CRC_W),
      .CNT_W(CNT_W), .CHECK_RULES(CHECK_RULES), .POLY(POLY), .INIT(INIT)
   ) u_fld (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take_hdr),
      .idx      (idx),
      .b        (bit_in),
      .rsv      (f_reserved),
      .ppi      (f_ppi),
      .nfi      (f_nfi),
      .syn      (f_sync),
      .stu      (f_startup),
      .id       (frame_id),
      .len      (pay_words),
      .cyc      (cycle_cnt),
      .hcrc_ok  (hcrc_ok),
      .fld_err  (fld_err),
      .hdr_done (hdr_done)
   );

   fr_pay_bytes #(.LEN_W(LEN_W), .BYTE_W(BYTE_W)) u_pay (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (hdr_last),
      .take      (take_pay),
      .b         (bit_in),
      .nbytes    (pay_bytes),
      .byte_vld  (byte_vld),
      .byte_data (byte_data),
      .last      (pay_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pay_done <= 1'b0;
      else        pay_done <= (hdr_last && len_zero) || (take_pay && pay_last);
   end

   p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_done && pay_words == '0) |-> pay_done);
   p_done_companion_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pay_done |-> (byte_vld || hdr_done));
endmodule

// File: tb/sim_fr_hdr_parse.sv
`timescale 1ns/1ps
module sim_fr_hdr_parse;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_vld = 1'b0;
   logic        bit_in = 1'b0;
   logic        sof = 1'b0;
   logic        hdr_done, f_reserved, f_ppi, f_nfi, f_sync, f_startup;
   logic [10:0] frame_id;
   logic [6:0]  pay_words;
   logic [7:0]  pay_bytes;
   logic [5:0]  cycle_cnt;
   logic        hcrc_ok, fld_err, byte_vld, pay_done;
   logic [7:0]  byte_data;

   int checks = 0;
   int errors = 0;
   bit ended  = 1'b0;

   always #4 clk = ~clk;

   fr_hdr_parse u0 (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in), .sof(sof),
      .hdr_done(hdr_done), .f_reserved(f_reserved), .f_ppi(f_ppi), .f_nfi(f_nfi),
      .f_sync(f_sync), .f_startup(f_startup), .frame_id(frame_id),
      .pay_words(pay_words), .pay_bytes(pay_bytes), .cycle_cnt(cycle_cnt),
      .hcrc_ok(hcrc_ok), .fld_err(fld_err), .byte_vld(byte_vld),
      .byte_data(byte_data), .pay_done(pay_done)
   );

   // entry: {ppi, nfi, sync, startup, id[10:0], len[6:0], cyc[5:0], crc_bad}
   localparam logic [28:0] VEC [5] = '{
      {1'b0, 1'b1, 1'b1, 1'b1, 11'h2A5, 7'd2, 6'd17, 1'b0},
      {1'b0, 1'b1, 1'b0, 1'b0, 11'h7FF, 7'd0, 6'd63, 1'b0},
      {1'b1, 1'b0, 1'b0, 1'b0, 11'h001, 7'd1, 6'd0,  1'b0},
      {1'b0, 1'b1, 1'b0, 1'b1, 11'h000, 7'd3, 6'd5,  1'b1},
      {1'b1, 1'b1, 1'b1, 1'b0, 11'h400, 7'd1, 6'd42, 1'b1}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [10:0] hcrc(input logic [19:0] d);
      logic [10:0] r;
      logic        fb;
      r = 11'h01A;
      for (int i = 19; i >= 0; i--) begin
         fb = r[10] ^ d[i];
         r  = {r[9:0], 1'b0};
         if (fb) r = r ^ 11'h385;
      end
      return r;
   endfunction

   function automatic logic [7:0] pbyte(input int k, input int j);
      return 8'((8'h3C + k * 8'h11) ^ (j * 8'h25));
   endfunction

   // sampled outputs of the last strobed bit
   logic s_hdr, s_bv, s_pd;
   logic [7:0] s_bd;

   task automatic send_bit(input logic b, input logic s, input int gap);
      @(negedge clk);
      bit_vld = 1'b1; bit_in = b; sof = s;
      @(negedge clk);
      s_hdr = hdr_done; s_bv = byte_vld; s_pd = pay_done; s_bd = byte_data;
      bit_vld = 1'b0; sof = 1'b0;
      // R9: strobe gaps must not change anything
      for (int g = 0; g < gap; g++) begin
         bit_in = ~bit_in;
         @(negedge clk);
      end
   endtask

   task automatic run_frame(input int k, input int limit, input int gap, input bit check);
      logic [28:0] v;
      logic        ppi, nfi, syn, stu, bad, rsv, b, exp_err;
      logic [10:0] id, crc;
      logic [6:0]  len;
      logic [5:0]  cyc;
      logic [40:0] hdr;
      int n, nh, nbv;
      v = VEC[k];
      {ppi, nfi, syn, stu, id, len, cyc, bad} = v;
      rsv = k[0];
      crc = hcrc({syn, stu, id, len});
      if (bad) crc[0] = ~crc[0];
      hdr = {1'b1, rsv, ppi, nfi, syn, stu, id, len, crc, cyc};
      exp_err = (id == 11'd0) || (stu && !syn) || (ppi && !nfi);
      n = 41 + 16 * int'(len);
      if (limit < n) n = limit;
      nh = 0; nbv = 0;
      for (int i = 0; i < n; i++) begin
         if (i < 41) b = hdr[40 - i];
         else        b = pbyte(k, (i - 41) / 8)[7 - ((i - 41) % 8)];
         send_bit(b, i == 0, gap);
         if (!check) continue;
         if (i == 23) chk(pay_bytes == 8'(2 * len), "R4", "pay_bytes", pay_bytes, 2 * len);
         if (s_hdr) begin
            nh++;
            chk(i == 40, "R2", "hdr_done bit index", i, 40);
            chk({f_reserved, f_ppi, f_nfi, f_sync, f_startup} == {rsv, ppi, nfi, syn, stu},
                "R2", "flags", {f_reserved, f_ppi, f_nfi, f_sync, f_startup},
                {rsv, ppi, nfi, syn, stu});
            chk(frame_id == id, "R3", "frame_id", frame_id, id);
            chk(pay_words == len, "R3", "pay_words", pay_words, len);
            chk(cycle_cnt == cyc, "R3", "cycle_cnt", cycle_cnt, cyc);
            chk(hcrc_ok == !bad, "R5", "hcrc_ok", hcrc_ok, !bad);
            chk(fld_err == exp_err, "R6", "fld_err", fld_err, exp_err);
            if (len == 0) chk(s_pd == 1'b1, "R8", "pay_done with hdr_done", s_pd, 1);
         end
         if (s_bv) begin
            chk(s_bd == pbyte(k, nbv), "R7", "byte_data", s_bd, pbyte(k, nbv));
            nbv++;
            chk(s_pd == (nbv == 2 * int'(len)), "R8", "pay_done at byte", s_pd,
                nbv == 2 * int'(len));
         end else if (s_pd && !s_hdr) begin
            chk(1'b0, "R8", "lone pay_done", s_pd, 0);
         end
      end
      if (check) begin
         chk(nh == 1, "R2", "hdr_done count", nh, 1);
         chk(nbv == 2 * int'(len), "R7", "byte count", nbv, 2 * len);
         // R9: bits after the end of the payload are ignored
         nh = 0;
         for (int j = 0; j < 12; j++) begin
            send_bit(j[0] ^ j[2], 1'b0, 0);
            if (s_hdr || s_bv || s_pd) nh++;
         end
         chk(nh == 0, "R9", "pulses after payload", nh, 0);
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!ended) begin
         ended = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk({hdr_done, byte_vld, pay_done, hcrc_ok, fld_err} == 5'b0, "R1",
          "pulses and flags", {hdr_done, byte_vld, pay_done, hcrc_ok, fld_err}, 0);
      chk(frame_id == 11'd0, "R1", "frame_id", frame_id, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(hdr_done == 1'b0 && pay_done == 1'b0, "R1", "idle after reset",
          {hdr_done, pay_done}, 0);

      // vector table walk
      for (int k = 0; k < 5; k++) run_frame(k, 1000, k % 3, 1'b1);

      // R10: partial frame cut by a new start
      run_frame(0, 20, 0, 1'b0);
      run_frame(3, 1000, 1, 1'b1);
      run_frame(2, 45, 0, 1'b0);
      run_frame(1, 1000, 0, 1'b1);
      chk(frame_id == 11'h7FF, "R10", "id after restart", frame_id, 11'h7FF);

      if (!ended) begin
         ended = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule